// File: doc/BRIEF.md
# Attention-Line Arbitrated Packet Sender

The block sends one packet from a small byte buffer over a shared open-drain data line. Before it sends anything it claims the bus through a second open-drain line, the attention line. When a start strobe arrives it looks at the attention line with its own driver released. If another node already holds that line low, the attempt ends at once with a busy result. If the line is high, the block pulls it low and waits two bit times. It then serializes every byte of the packet and finally lets the attention line go.

Each byte goes out as an asynchronous character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A one bit is sent by releasing the line, so the external pull-up brings it high. Halfway through each released bit the serializer reads the line back. If the line is low at that point, another driver is fighting the bus, and the whole packet is abandoned with a collision result. Three wrapping counters record how many attempts ended in success, busy and collision.

Both lines are modelled as a pair of signals. A drive output of 1 pulls the wire low, and the sense input carries the wire level, where 1 means high. The buffer read port is combinational: `buf_data_i` must present the byte at `buf_addr_o` in the same cycle.

Top module: `atn_pkt_sender`

## Requirements
- R1: After reset both drive outputs are 0, all three result outputs are 0 and all three counters read 0.
- R2: A start strobe taken while idle with `attn_sense_i` low produces a one-cycle `busy_o` in the next cycle. Neither line is driven, and the busy counter rises by one.
- R3: A start strobe taken while idle with `attn_sense_i` high sets `attn_drive_o` to 1 in the next cycle. `attn_drive_o` stays 1 for the whole packet, and `data_drive_o` is only ever 1 while `attn_drive_o` is 1.
- R4: The first start bit begins no sooner than 2*BIT_CYCLES clock cycles after `attn_drive_o` rises, and no later than four cycles beyond that.
- R5: Each byte is framed as BIT_CYCLES cycles of start bit (line driven), then eight data bits with the LSB first (a 0 drives the line, a 1 releases it), then one released stop bit of BIT_CYCLES cycles.
- R6: The packet length is (byte at offset 1) + 3. The bytes are sent in buffer order from offset 0, which holds the destination address.
- R7: If a released data bit senses the line low at its mid-point, the block stops driving the data line, sends no further bytes and ends with a one-cycle `coll_o`.
- R8: In the cycle that `ok_o` or `coll_o` is 1, both `attn_drive_o` and `data_drive_o` are already 0.
- R9: Every accepted attempt ends with exactly one of `ok_o`, `busy_o` or `coll_o`, and it increments exactly one matching counter: sent, busy or collision.
- R10: The counters are CNT_W bits wide and wrap from all-ones to zero.
- R11: A start strobe that arrives while a packet is in progress is ignored. No busy result is recorded, and only the one packet is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe to start one send attempt |
| buf_addr_o | output | ADDR_W | Buffer byte offset being read |
| buf_data_i | input | 8 | Buffer byte at `buf_addr_o` |
| attn_drive_o | output | 1 | 1 pulls the attention line low |
| attn_sense_i | input | 1 | Attention line level (1 = high) |
| data_drive_o | output | 1 | 1 pulls the data line low |
| data_sense_i | input | 1 | Data line level (1 = high) |
| ok_o | output | 1 | One-cycle pulse: packet sent |
| busy_o | output | 1 | One-cycle pulse: bus was busy |
| coll_o | output | 1 | One-cycle pulse: collision, packet abandoned |
| cnt_sent_o | output | CNT_W | Count of successful packets |
| cnt_busy_o | output | CNT_W | Count of busy attempts |
| cnt_coll_o | output | CNT_W | Count of collisions |

## Verification
The embedded properties check several rules on every cycle. The data line is never driven without the attention claim, and the data line stays quiet during the guard interval. A refused start never claims the bus, at most one result fires at a time, and both lines are free when a result fires. Each counter steps by exactly one or holds. A collision can only follow a sensed low level, and it frees the line at once. Other behaviour is visible only in the bench's scenarios, which decode the wire. These scenarios show that the byte order, the LSB-first framing and the length-plus-three byte count match the buffer. They also show that the guard delay falls in its window, that a collision on a chosen byte and bit cuts the packet short there, that a start strobe sent mid-packet changes nothing, and that the counters wrap.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_GUARD, PS_LOAD, PS_WAIT} pkt_st_e;
  typedef enum logic [1:0] {SS_IDLE, SS_START, SS_DATA, SS_STOP} ser_st_e;
  localparam int RES_OK   = 0;
  localparam int RES_BUSY = 1;
  localparam int RES_COLL = 2;
  localparam int RES_NUM  = 3;
  localparam int FRAME_OVERHEAD = 3; // destination, length, checksum
endpackage

// File: rtl/pkt_stat_ctr.sv
module pkt_stat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] q_o
);
  logic [CNT_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (inc_i) q_d = q_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R10: one step per event, wrapping modulo 2^CNT_W
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> q_o == CNT_W'($past(q_o) + 1'b1));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(q_o));
endmodule

// File: rtl/pkt_bit_ser.sv
module pkt_bit_ser
  import pkt_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] byte_i,
  input  logic       line_i,
  output logic       drive_o,
  output logic       done_o,
  output logic       coll_o
);
  localparam int CW   = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int HALF = BIT_CYCLES / 2;

  ser_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          done_q, done_d, coll_q, coll_d;
  logic          bit_end, mid_check;

  assign bit_end   = (cnt_q == CW'(BIT_CYCLES - 1));
  assign mid_check = (st_q == SS_DATA) && sh_q[0] && (cnt_q == CW'(HALF));

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    coll_d = 1'b0;
    cnt_d  = (st_q == SS_IDLE || bit_end) ? '0 : cnt_q + 1'b1;
    case (st_q)
      SS_IDLE: if (go_i) begin
        st_d  = SS_START;
        sh_d  = byte_i;
        bit_d = '0;
      end
      SS_START: if (bit_end) st_d = SS_DATA;
      SS_DATA: begin
        if (mid_check && !line_i) begin
          coll_d = 1'b1;
          done_d = 1'b1;
          st_d   = SS_IDLE;
        end else if (bit_end) begin
          sh_d  = {1'b0, sh_q[7:1]};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) st_d = SS_STOP;
        end
      end
      SS_STOP: if (bit_end) begin
        done_d = 1'b1;
        st_d   = SS_IDLE;
      end
      default: st_d = SS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      coll_q <= coll_d;
    end
  end

  assign drive_o = (st_q == SS_START) || (st_q == SS_DATA && !sh_q[0]);
  assign done_o  = done_q;
  assign coll_o  = coll_q;

  // R7: a collision frees the line and only follows a sensed low
  a_r7_coll_frees_line: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> !drive_o);
  a_r7_coll_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> !$past(line_i));
  // R5: an accepted byte opens with a driven start bit
  a_r5_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && st_q == SS_IDLE) |=> drive_o);
endmodule

// File: rtl/atn_pkt_sender.sv
module atn_pkt_sender
  import pkt_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic              attn_drive_o,
  input  logic              attn_sense_i,
  output logic              data_drive_o,
  input  logic              data_sense_i,
  output logic              ok_o,
  output logic              busy_o,
  output logic              coll_o,
  output logic [CNT_W-1:0]  cnt_sent_o,
  output logic [CNT_W-1:0]  cnt_busy_o,
  output logic [CNT_W-1:0]  cnt_coll_o
);
  localparam int GUARD_CYC = 2 * BIT_CYCLES;
  localparam int GW        = $clog2(GUARD_CYC);
  localparam int IW        = 9; // up to 255 + FRAME_OVERHEAD bytes

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pkt_st_e             st_q, st_d;
  logic [GW-1:0]       gcnt_q, gcnt_d;
  logic [IW-1:0]       idx_q, idx_d, total_q, total_d;
  logic [RES_NUM-1:0]  res_q, res_d;
  logic                tx_go, tx_done, tx_coll;
  logic [CNT_W-1:0]    cnt_all [RES_NUM];

  always_comb begin
    st_d    = st_q;
    gcnt_d  = gcnt_q;
    idx_d   = idx_q;
    total_d = total_q;
    res_d   = '0;
    tx_go   = 1'b0;
    case (st_q)
      PS_IDLE: if (start_i) begin
        if (!attn_sense_i) res_d[RES_BUSY] = 1'b1;
        else begin
          st_d   = PS_GUARD;
          gcnt_d = '0;
        end
      end
      PS_GUARD: begin
        gcnt_d = gcnt_q + 1'b1;
        if (gcnt_q == GW'(GUARD_CYC - 1)) begin
          total_d = {1'b0, buf_data_i} + IW'(FRAME_OVERHEAD);
          idx_d   = '0;
          st_d    = PS_LOAD;
        end
      end
      PS_LOAD: begin
        tx_go = 1'b1;
        st_d  = PS_WAIT;
      end
      PS_WAIT: if (tx_done) begin
        if (tx_coll) begin
          res_d[RES_COLL] = 1'b1;
          st_d            = PS_IDLE;
        end else if (idx_q == total_q - 1'b1) begin
          res_d[RES_OK] = 1'b1;
          st_d          = PS_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = PS_LOAD;
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_IDLE;
      gcnt_q  <= '0;
      idx_q   <= '0;
      total_q <= '0;
      res_q   <= '0;
    end else begin
      st_q    <= st_d;
      gcnt_q  <= gcnt_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      res_q   <= res_d;
    end
  end

  assign buf_addr_o   = (st_q == PS_GUARD) ? ADDR_W'(1) : idx_q[ADDR_W-1:0];
  assign attn_drive_o = (st_q != PS_IDLE);
  assign ok_o         = res_q[RES_OK];
  assign busy_o       = res_q[RES_BUSY];
  assign coll_o       = res_q[RES_COLL];

  pkt_bit_ser #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
    .clk     (clk),
    .rst_n   (rst_ni),
    .go_i    (tx_go),
    .byte_i  (buf_data_i),
    .line_i  (data_sense_i),
    .drive_o (data_drive_o),
    .done_o  (tx_done),
    .coll_o  (tx_coll)
  );

  for (genvar g = 0; g < RES_NUM; g++) begin : g_ctr
    pkt_stat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_ni),
      .inc_i (res_d[g]),
      .q_o   (cnt_all[g])
    );
  end

  assign cnt_sent_o = cnt_all[RES_OK];
  assign cnt_busy_o = cnt_all[RES_BUSY];
  assign cnt_coll_o = cnt_all[RES_COLL];

  // R3: the data line is only driven under the attention claim
  a_r3_data_needs_attn: assert property (@(posedge clk) disable iff (!rst_ni)
    data_drive_o |-> attn_drive_o);
  // R2: a refused start claims nothing
  a_r2_busy_no_claim: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == PS_IDLE && start_i && !attn_sense_i) |=> (busy_o && !attn_drive_o));
  // R4: data line quiet during the guard interval
  a_r4_guard_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == PS_GUARD) |-> !data_drive_o);
  // R9: one result at a time
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ok_o, busy_o, coll_o}));
  // R8: both lines free when the packet result appears
  a_r8_released: assert property (@(posedge clk) disable iff (!rst_ni)
    (ok_o || coll_o) |-> (!attn_drive_o && !data_drive_o));
  // R11: a strobe during a packet never yields busy
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q != PS_IDLE && start_i) |=> !busy_o);
endmodule

// File: tb/sim_atn_pkt_sender.sv
module sim_atn_pkt_sender;
  localparam int B      = 8;
  localparam int AW     = 5;
  localparam int DEPTH  = 1 << AW;
  localparam int MAXLEN = DEPTH - 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ext_attn_low = 1'b0;
  logic        ext_data_low = 1'b0;
  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] buf_addr;
  logic [7:0]  buf_data;
  logic        attn_drive, data_drive, attn_sense, data_sense;
  logic        ok, busy, coll;
  logic [15:0] c_sent, c_busy, c_coll;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cap [300];
  int cap_n = 0;

  always #10 clk = ~clk; // 50 MHz

  assign buf_data   = mem[buf_addr];
  assign attn_sense = !(attn_drive || ext_attn_low);
  assign data_sense = !(data_drive || ext_data_low);

  atn_pkt_sender #(.BIT_CYCLES(B), .ADDR_W(AW), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .buf_addr_o(buf_addr), .buf_data_i(buf_data),
    .attn_drive_o(attn_drive), .attn_sense_i(attn_sense),
    .data_drive_o(data_drive), .data_sense_i(data_sense),
    .ok_o(ok), .busy_o(busy), .coll_o(coll),
    .cnt_sent_o(c_sent), .cnt_busy_o(c_busy), .cnt_coll_o(c_coll)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wire decoder: centre-samples start, 8 data bits LSB first
  initial begin
    forever begin
      @(negedge clk);
      if (!data_sense) begin
        logic [7:0] v;
        v = '0;
        repeat (B/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (B) @(negedge clk);
          v[i] = data_sense;
        end
        cap[cap_n] = v;
        cap_n++;
        while (!data_sense) @(negedge clk);
      end
    end
  end

  task automatic inject(input int k, input int b);
    while (cap_n != k) @(negedge clk);
    while (!data_sense) @(negedge clk);
    while (data_sense) @(negedge clk);
    repeat ((1 + b) * B) @(negedge clk);
    ext_data_low = 1'b1;
    repeat (B - 1) @(negedge clk);
    ext_data_low = 1'b0;
  endtask

  function automatic int exp_bytes(input int len);
    return len + 3;
  endfunction

  // ck < 0: no collision; poke: strobe start mid-packet
  task automatic run_pkt(input int len, input int ck, input int cb, input bit poke);
    int s0, b0, c0, gap, cyc, nexp;
    bit held, got_ok, got_coll, rel, match;
    mem[0] = 8'($urandom);
    mem[1] = 8'(len);
    for (int i = 2; i < DEPTH; i++) mem[i] = 8'($urandom);
    if (ck >= 0) mem[ck][cb] = 1'b1;
    s0 = c_sent; b0 = c_busy; c0 = c_coll;
    cap_n = 0;
    if (ck >= 0) fork inject(ck, cb); join_none
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(attn_drive == 1'b1, "R3 attn claimed", attn_drive, 1);
    gap = 1;
    while (!data_drive && gap < 10 * B) begin @(negedge clk); gap++; end
    chk(gap >= 2 * B + 1 && gap <= 2 * B + 5, "R4 guard delay", gap, 2 * B + 2);
    held = 1'b1; cyc = 0;
    while (!(ok || coll || busy)) begin
      held &= attn_drive;
      start = poke && (cyc == 30);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    got_ok = ok; got_coll = coll;
    rel = !attn_drive && !data_drive;
    repeat (12 * B) @(negedge clk);
    chk(held, "R3 attn held through packet", held, 1);
    chk(rel, "R8 lines released at result", rel, 1);
    nexp = (ck < 0) ? exp_bytes(len) : ck + 1;
    chk(cap_n == nexp, (ck < 0) ? "R6 byte count" : "R7 cut short", cap_n, nexp);
    match = 1'b1;
    for (int i = 0; i < nexp - ((ck < 0) ? 0 : 1); i++) match &= (cap[i] == mem[i]);
    chk(match, "R5 R6 bytes on wire", match, 1);
    if (ck < 0) begin
      chk(got_ok, "R9 ok result", got_ok, 1);
      chk(c_sent == 16'(s0 + 1) && c_coll == 16'(c0), "R9 sent counter", c_sent, s0 + 1);
    end else begin
      chk(got_coll, "R7 collision result", got_coll, 1);
      chk(c_coll == 16'(c0 + 1) && c_sent == 16'(s0), "R9 coll counter", c_coll, c0 + 1);
    end
    chk(c_busy == 16'(b0), poke ? "R11 mid strobe ignored" : "R9 busy unchanged", c_busy, b0);
  endtask

  initial begin
    int b0, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!attn_drive && !data_drive, "R1 lines idle", {attn_drive, data_drive}, 0);
    chk(!ok && !busy && !coll, "R1 no result", {ok, busy, coll}, 0);
    chk(c_sent == 0 && c_busy == 0 && c_coll == 0, "R1 counters zero", c_sent + c_busy + c_coll, 0);

    // R2 busy
    ext_attn_low = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy pulse", busy, 1);
    chk(!attn_drive && !data_drive, "R2 no drive", {attn_drive, data_drive}, 0);
    @(negedge clk);
    chk(c_busy == 16'd1, "R2 busy count", c_busy, 1);
    chk(!busy, "R2 one-cycle pulse", busy, 0);
    ext_attn_low = 1'b0;
    repeat (3) @(negedge clk);

    run_pkt(0, -1, 0, 1'b0);        // shortest packet
    run_pkt(MAXLEN, -1, 0, 1'b0);   // fullest buffer
    run_pkt(4, -1, 0, 1'b1);        // R11 strobe mid-packet
    run_pkt(3, 0, 0, 1'b0);         // R7 collision on first byte, bit 0
    run_pkt(2, 4, 7, 1'b0);         // R7 collision on last byte, bit 7
    for (int t = 0; t < 14; t++) begin
      int len, k;
      len = $urandom_range(0, 12);
      if ($urandom_range(0, 2) == 0) begin
        k = $urandom_range(0, len + 2);
        if (k == 1) k = 0;
        run_pkt(len, k, $urandom_range(0, 7), 1'b0);
      end else begin
        run_pkt(len, -1, 0, 1'b0);
      end
    end

    // R10 wrap of the busy counter
    ext_attn_low = 1'b1;
    b0 = c_busy;
    n = 16'hFFFF - b0;
    start = 1'b1;
    repeat (n) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(c_busy == 16'hFFFF, "R10 reaches all ones", c_busy, 16'hFFFF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(c_busy == 16'h0000, "R10 wraps to zero", c_busy, 0);
    ext_attn_low = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule